// File: doc/BRIEF.md
# Address/Data Trigger Match Unit

This block compares every instruction fetch, load and store against a small bank of programmable watch triggers and reports which one fired. Each trigger has a compare value, a compare mode, a choice of address or data as the compared quantity, per-operation and per-privilege enable bits, a chain flag, an action code and a timing bit. The configuration comes in as flat buses, with trigger `i` occupying slice `i` of each bus. The access side supplies a valid strobe, the operation kind, the address, the data, the current privilege, a debug-mode flag and a 32-bit-mode flag.

The unit evaluates all triggers in one cycle and resolves chains and priority. The result is registered. The trap or debug-entry sequencer downstream uses `hit_timing` to decide whether to block the access (timing 0, used for checks made before a store commits) or to report it after completion (timing 1, used for checks made once load data is available). The unit only reports which trigger won. Acting on the hit is left to the sequencer.

Top module: `trig_match_unit`

## Requirements
- R1: After synchronous reset `hit`, `hit_idx`, `hit_action` and `hit_timing` are all zero.
- R2: The outputs are registered. The result for an access appears on the clock edge that samples `acc_valid`=1. A cycle with `acc_valid`=0 gives `hit`=0 at the next edge.
- R3: While `dbg_mode` is 1 no trigger matches.
- R4: A trigger takes part only if it is enabled for both the operation and the privilege. The operation enable is `cfg_op_en` bit `acc_op`, with codes 0 execute, 1 load and 2 store. Code 3 never matches. The privilege enable is `cfg_priv_en` bit `cur_priv`, with codes 0 U, 1 S, 2 H and 3 M.
- R5: `cfg_sel`=0 compares `acc_addr` and `cfg_sel`=1 compares `acc_data`. When `narrow_mode`=1, the compared value is cut to its low 32 bits before comparison. The compare register is not cut.
- R6: Mode 0 matches when value equals compare. Mode 2 matches when value is greater than or equal to compare. Mode 3 matches when value is less than compare. Modes 2 and 3 are unsigned.
- R7: Mode 1 counts N, the number of contiguous ones from bit 0 of the compare register. It clears the low N bits of both value and compare, then tests for equality. An all-ones compare matches any value.
- R8: Modes 4 and 5 take the upper half of the compare register as a mask, M. Mode 4 matches when (value & M) equals (compare & M). Mode 5 matches when ((value >> XLEN/2) & M) equals (compare & M).
- R9: Mode codes 6 and 7 never match.
- R10: A matching trigger with `cfg_chain`=1 never hits by itself, and evaluation moves to the next index. Only a matching trigger with chain clear produces a hit. A chained trigger that fails causes every following trigger to be skipped, up to and including the next one with chain clear.
- R11: When several triggers hit, the lowest index wins. `hit_idx`, `hit_action` and `hit_timing` come from that trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe |
| acc_op | input | 2 | Operation: 0 execute, 1 load, 2 store |
| acc_addr | input | XLEN | Access address |
| acc_data | input | XLEN | Access data value |
| cur_priv | input | 2 | Privilege: 0 U, 1 S, 2 H, 3 M |
| dbg_mode | input | 1 | Core is in debug mode |
| narrow_mode | input | 1 | 32-bit mode, truncates compared value |
| cfg_op_en | input | 3*NTRIG | Per-trigger operation enables |
| cfg_priv_en | input | 4*NTRIG | Per-trigger privilege enables |
| cfg_sel | input | NTRIG | Per-trigger address(0)/data(1) select |
| cfg_mode | input | 3*NTRIG | Per-trigger compare mode |
| cfg_chain | input | NTRIG | Per-trigger chain flag |
| cfg_timing | input | NTRIG | Per-trigger timing bit |
| cfg_action | input | ACTW*NTRIG | Per-trigger action code |
| cfg_cmp | input | XLEN*NTRIG | Per-trigger compare value |
| hit | output | 1 | A trigger fired |
| hit_idx | output | IW | Index of winning trigger |
| hit_action | output | ACTW | Action of winning trigger |
| hit_timing | output | 1 | Timing of winning trigger |

## Verification
Directed accesses place the value one step either side of each compare boundary. This separates equality, unsigned ordering, the trailing-ones mask and the half-word masks. Paired cases flip a single input, such as the debug flag, the privilege, the operation, the select bit or 32-bit mode, so that a filter which is missing or inverted shows up. Chain cases cover four patterns: a passing chain, a broken chain that swallows its terminator, a dangling chained last trigger, and two simultaneous hits, which show the priority order. Random traffic aims accesses at the programmed compare values under random modes, chains and enables, and is compared against a bench model.

// File: rtl/trig_pkg.sv
package trig_pkg;
  typedef enum logic [1:0] {
    OP_EXEC  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_STORE = 2'd2
  } trig_op_e;

  typedef enum logic [2:0] {
    MM_EQ   = 3'd0,
    MM_POW2 = 3'd1,
    MM_GE   = 3'd2,
    MM_LT   = 3'd3,
    MM_MLO  = 3'd4,
    MM_MHI  = 3'd5
  } trig_mode_e;

  localparam int OP_BITS   = 3;
  localparam int PRIV_BITS = 4;
  localparam int MODE_BITS = 3;
endpackage

// File: rtl/trig_slot.sv
module trig_slot
  import trig_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [1:0]           acc_op,
  input  logic [1:0]           cur_priv,
  input  logic [XLEN-1:0]      acc_addr,
  input  logic [XLEN-1:0]      acc_data,
  input  logic                 dbg_mode,
  input  logic                 narrow_mode,
  input  logic [OP_BITS-1:0]   op_en,
  input  logic [PRIV_BITS-1:0] priv_en,
  input  logic                 sel,
  input  logic [MODE_BITS-1:0] mode,
  input  logic [XLEN-1:0]      cmp,
  output logic                 match
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] value;
  logic [XLEN-1:0] pow2_mask;
  logic [XLEN-1:0] half_mask;
  logic            eligible;
  logic            cmp_ok;

  always_comb begin
    value = sel ? acc_data : acc_addr;
    if (narrow_mode) value = value & {{(XLEN-32){1'b0}}, {32{1'b1}}};
  end

  // Trailing-ones run: bit i is cleared while cmp[i:0] is all ones.
  always_comb begin
    logic run;
    run = 1'b1;
    for (int i = 0; i < XLEN; i++) begin
      run = run & cmp[i];
      pow2_mask[i] = ~run;
    end
  end

  assign half_mask = cmp >> HALF;

  always_comb begin
    case (trig_mode_e'(mode))
      MM_EQ:   cmp_ok = (value == cmp);
      MM_POW2: cmp_ok = ((value & pow2_mask) == (cmp & pow2_mask));
      MM_GE:   cmp_ok = (value >= cmp);
      MM_LT:   cmp_ok = (value < cmp);
      MM_MLO:  cmp_ok = ((value & half_mask) == (cmp & half_mask));
      MM_MHI:  cmp_ok = (((value >> HALF) & half_mask) == (cmp & half_mask));
      default: cmp_ok = 1'b0;
    endcase
  end

  always_comb begin
    eligible = 1'b0;
    if (!dbg_mode && acc_op != 2'd3)
      eligible = op_en[acc_op] & priv_en[cur_priv];
  end

  assign match = eligible & cmp_ok;
endmodule

// File: rtl/trig_resolve.sv
module trig_resolve #(
  parameter int NTRIG = 4,
  parameter int IW    = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
  input  logic [NTRIG-1:0] raw,
  input  logic [NTRIG-1:0] chain,
  output logic             found,
  output logic [IW-1:0]    idx
);
  always_comb begin
    logic link_ok;
    link_ok = 1'b1;
    found   = 1'b0;
    idx     = '0;
    for (int i = 0; i < NTRIG; i++) begin
      if (!link_ok) begin
        if (!chain[i]) link_ok = 1'b1;
      end else if (raw[i]) begin
        if (!chain[i] && !found) begin
          found = 1'b1;
          idx   = IW'(i);
        end
      end else if (chain[i]) begin
        link_ok = 1'b0;
      end
    end
  end
endmodule

// File: rtl/trig_match_unit.sv
module trig_match_unit
  import trig_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int NTRIG = 4,
  parameter int ACTW  = 3,
  localparam int IW   = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       acc_valid,
  input  logic [1:0]                 acc_op,
  input  logic [XLEN-1:0]            acc_addr,
  input  logic [XLEN-1:0]            acc_data,
  input  logic [1:0]                 cur_priv,
  input  logic                       dbg_mode,
  input  logic                       narrow_mode,
  input  logic [NTRIG*OP_BITS-1:0]   cfg_op_en,
  input  logic [NTRIG*PRIV_BITS-1:0] cfg_priv_en,
  input  logic [NTRIG-1:0]           cfg_sel,
  input  logic [NTRIG*MODE_BITS-1:0] cfg_mode,
  input  logic [NTRIG-1:0]           cfg_chain,
  input  logic [NTRIG-1:0]           cfg_timing,
  input  logic [NTRIG*ACTW-1:0]      cfg_action,
  input  logic [NTRIG*XLEN-1:0]      cfg_cmp,
  output logic                       hit,
  output logic [IW-1:0]              hit_idx,
  output logic [ACTW-1:0]            hit_action,
  output logic                       hit_timing
);
  logic [NTRIG-1:0] raw;
  logic             found;
  logic [IW-1:0]    win;

  for (genvar g = 0; g < NTRIG; g++) begin : g_slot
    trig_slot #(.XLEN(XLEN)) u_slot (
      .acc_op      (acc_op),
      .cur_priv    (cur_priv),
      .acc_addr    (acc_addr),
      .acc_data    (acc_data),
      .dbg_mode    (dbg_mode),
      .narrow_mode (narrow_mode),
      .op_en       (cfg_op_en[g*OP_BITS +: OP_BITS]),
      .priv_en     (cfg_priv_en[g*PRIV_BITS +: PRIV_BITS]),
      .sel         (cfg_sel[g]),
      .mode        (cfg_mode[g*MODE_BITS +: MODE_BITS]),
      .cmp         (cfg_cmp[g*XLEN +: XLEN]),
      .match       (raw[g])
    );
  end

  trig_resolve #(.NTRIG(NTRIG), .IW(IW)) u_resolve (
    .raw   (raw),
    .chain (cfg_chain),
    .found (found),
    .idx   (win)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hit        <= 1'b0;
      hit_idx    <= '0;
      hit_action <= '0;
      hit_timing <= 1'b0;
    end else if (acc_valid && found) begin
      hit        <= 1'b1;
      hit_idx    <= win;
      hit_action <= cfg_action[int'(win)*ACTW +: ACTW];
      hit_timing <= cfg_timing[win];
    end else begin
      hit        <= 1'b0;
      hit_idx    <= '0;
      hit_action <= '0;
      hit_timing <= 1'b0;
    end
  end
endmodule

// File: rtl/trig_match_checks.sv
module trig_match_checks #(
  parameter int XLEN  = 64,
  parameter int NTRIG = 4,
  parameter int ACTW  = 3,
  localparam int IW   = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
  input logic               clk,
  input logic               rst,
  input logic               acc_valid,
  input logic [1:0]         acc_op,
  input logic               dbg_mode,
  input logic [NTRIG*3-1:0] cfg_op_en,
  input logic [NTRIG-1:0]   cfg_chain,
  input logic               hit,
  input logic [IW-1:0]      hit_idx
);
  logic [1:0]         op_q;
  logic [NTRIG*3-1:0] op_en_q;
  logic [NTRIG-1:0]   chain_q;
  logic [2:0]         win_op_en;

  always_ff @(posedge clk) begin
    op_q    <= acc_op;
    op_en_q <= cfg_op_en;
    chain_q <= cfg_chain;
  end

  always_comb win_op_en = op_en_q[int'(hit_idx)*3 +: 3];

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !hit);

  assert_debug_silent_R3: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && dbg_mode) |=> !hit);

  assert_op_enabled_R4: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> (!hit || (op_q != 2'd3 && win_op_en[op_q])));

  assert_chain_end_R10: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> (!hit || !chain_q[hit_idx]));

  assert_idx_range_R11: assert property (@(posedge clk) disable iff (rst)
    hit |-> (int'(hit_idx) < NTRIG));
endmodule

bind trig_match_unit trig_match_checks #(.XLEN(XLEN), .NTRIG(NTRIG), .ACTW(ACTW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .acc_valid (acc_valid),
  .acc_op    (acc_op),
  .dbg_mode  (dbg_mode),
  .cfg_op_en (cfg_op_en),
  .cfg_chain (cfg_chain),
  .hit       (hit),
  .hit_idx   (hit_idx)
);

// File: tb/sim_trig_match_unit.sv
`timescale 1ns/1ps
module sim_trig_match_unit;
  localparam int XLEN = 64;
  localparam int NT   = 4;
  localparam int AW   = 3;
  localparam int IW   = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic            acc_valid = 1'b0;
  logic [1:0]      acc_op = '0;
  logic [XLEN-1:0] acc_addr = '0;
  logic [XLEN-1:0] acc_data = '0;
  logic [1:0]      cur_priv = '0;
  logic            dbg_mode = 1'b0;
  logic            narrow_mode = 1'b0;

  logic [2:0]      c_op  [NT];
  logic [3:0]      c_pv  [NT];
  logic [2:0]      c_md  [NT];
  logic            c_sel [NT];
  logic            c_ch  [NT];
  logic            c_tm  [NT];
  logic [AW-1:0]   c_act [NT];
  logic [XLEN-1:0] c_cmp [NT];

  logic [NT*3-1:0]    cfg_op_en;
  logic [NT*4-1:0]    cfg_priv_en;
  logic [NT-1:0]      cfg_sel, cfg_chain, cfg_timing;
  logic [NT*3-1:0]    cfg_mode;
  logic [NT*AW-1:0]   cfg_action;
  logic [NT*XLEN-1:0] cfg_cmp;

  always_comb begin
    for (int i = 0; i < NT; i++) begin
      cfg_op_en[i*3 +: 3]      = c_op[i];
      cfg_priv_en[i*4 +: 4]    = c_pv[i];
      cfg_mode[i*3 +: 3]       = c_md[i];
      cfg_sel[i]               = c_sel[i];
      cfg_chain[i]             = c_ch[i];
      cfg_timing[i]            = c_tm[i];
      cfg_action[i*AW +: AW]   = c_act[i];
      cfg_cmp[i*XLEN +: XLEN]  = c_cmp[i];
    end
  end

  logic          hit;
  logic [IW-1:0] hit_idx;
  logic [AW-1:0] hit_action;
  logic          hit_timing;

  trig_match_unit #(.XLEN(XLEN), .NTRIG(NT), .ACTW(AW)) u0 (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_op(acc_op),
    .acc_addr(acc_addr), .acc_data(acc_data), .cur_priv(cur_priv),
    .dbg_mode(dbg_mode), .narrow_mode(narrow_mode),
    .cfg_op_en(cfg_op_en), .cfg_priv_en(cfg_priv_en), .cfg_sel(cfg_sel),
    .cfg_mode(cfg_mode), .cfg_chain(cfg_chain), .cfg_timing(cfg_timing),
    .cfg_action(cfg_action), .cfg_cmp(cfg_cmp),
    .hit(hit), .hit_idx(hit_idx), .hit_action(hit_action), .hit_timing(hit_timing)
  );

  int n_chk = 0;
  int n_bad = 0;

  function automatic bit cmp_model(logic [2:0] md, logic [XLEN-1:0] v, logic [XLEN-1:0] c);
    logic [XLEN-1:0] m;
    int n;
    case (md)
      3'd0: return v == c;
      3'd1: begin
        n = 0;
        while (n < XLEN && c[n]) n++;
        m = (n >= XLEN) ? '0 : ~((64'd1 << n) - 64'd1);
        return (v & m) == (c & m);
      end
      3'd2: return v >= c;
      3'd3: return v < c;
      3'd4: begin m = c >> 32; return (v & m) == (c & m); end
      3'd5: begin m = c >> 32; return ((v >> 32) & m) == (c & m); end
      default: return 1'b0;
    endcase
  endfunction

  function automatic void model(output bit eh, output int ei);
    bit ok = 1'b1;
    logic [XLEN-1:0] v;
    bit m;
    eh = 1'b0; ei = 0;
    for (int i = 0; i < NT; i++) begin
      v = c_sel[i] ? acc_data : acc_addr;
      if (narrow_mode) v = {32'd0, v[31:0]};
      m = !dbg_mode && acc_op != 2'd3 && c_op[i][acc_op] && c_pv[i][cur_priv]
          && cmp_model(c_md[i], v, c_cmp[i]);
      if (!ok) begin
        if (!c_ch[i]) ok = 1'b1;
      end else if (m) begin
        if (!c_ch[i] && !eh) begin eh = 1'b1; ei = i; end
      end else if (c_ch[i]) ok = 1'b0;
    end
  endfunction

  task automatic check(string tag, bit eh, int ei, logic [AW-1:0] ea, bit et);
    n_chk++;
    if (hit !== eh || (eh && (hit_idx !== IW'(ei) || hit_action !== ea || hit_timing !== et))) begin
      n_bad++;
      $display("FAIL %s: hit=%0b idx=%0d act=%0d tim=%0b expected hit=%0b idx=%0d act=%0d tim=%0b",
               tag, hit, hit_idx, hit_action, hit_timing, eh, ei, ea, et);
    end
  endtask

  task automatic clear_cfg();
    for (int i = 0; i < NT; i++) begin
      c_op[i] = '0; c_pv[i] = '0; c_md[i] = '0; c_sel[i] = 1'b0;
      c_ch[i] = 1'b0; c_tm[i] = 1'b0; c_act[i] = '0; c_cmp[i] = '0;
    end
  endtask

  task automatic arm(int i, logic [2:0] md, logic [XLEN-1:0] c, logic ch, logic [AW-1:0] a, logic t);
    c_op[i] = 3'b111; c_pv[i] = 4'b1111; c_md[i] = md; c_cmp[i] = c;
    c_ch[i] = ch; c_act[i] = a; c_tm[i] = t; c_sel[i] = 1'b0;
  endtask

  task automatic access(logic [1:0] op, logic [1:0] pv, logic [XLEN-1:0] ad, logic [XLEN-1:0] dt);
    acc_valid = 1'b1; acc_op = op; cur_priv = pv; acc_addr = ad; acc_data = dt;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R2: watchdog expired, got no finish, expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit eh;
    int ei;
    void'($urandom(32'd20240611));
    clear_cfg();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset", 1'b0, 0, '0, 1'b0);
    if (hit_idx !== '0 || hit_action !== '0 || hit_timing !== 1'b0) begin
      n_bad++; $display("FAIL R1: outputs not zero after reset, expected 0");
    end

    arm(0, 3'd0, 64'h1000, 1'b0, 3'd5, 1'b1);
    access(2'd0, 2'd3, 64'h1000, 64'h0);
    check("R6 equal hit", 1'b1, 0, 3'd5, 1'b1);
    access(2'd0, 2'd3, 64'h1001, 64'h0);
    check("R6 equal miss", 1'b0, 0, '0, 1'b0);
    dbg_mode = 1'b1;
    access(2'd0, 2'd3, 64'h1000, 64'h0);
    check("R3 debug", 1'b0, 0, '0, 1'b0);
    dbg_mode = 1'b0;
    c_pv[0] = 4'b1000;
    access(2'd0, 2'd0, 64'h1000, 64'h0);
    check("R4 priv off", 1'b0, 0, '0, 1'b0);
    c_pv[0] = 4'b1111; c_op[0] = 3'b100;
    access(2'd1, 2'd3, 64'h1000, 64'h0);
    check("R4 op off", 1'b0, 0, '0, 1'b0);
    access(2'd2, 2'd3, 64'h1000, 64'h0);
    check("R4 store on", 1'b1, 0, 3'd5, 1'b1);
    acc_valid = 1'b0;
    @(negedge clk);
    check("R2 idle", 1'b0, 0, '0, 1'b0);

    clear_cfg();
    arm(0, 3'd2, 64'h10, 1'b0, 3'd1, 1'b0);
    access(2'd1, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
    check("R6 GE unsigned", 1'b1, 0, 3'd1, 1'b0);
    c_md[0] = 3'd3;
    access(2'd1, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
    check("R6 LT unsigned miss", 1'b0, 0, '0, 1'b0);
    access(2'd1, 2'd1, 64'hF, 64'h0);
    check("R6 LT hit", 1'b1, 0, 3'd1, 1'b0);

    arm(0, 3'd1, 64'h1007, 1'b0, 3'd2, 1'b0);
    access(2'd0, 2'd2, 64'h1003, 64'h0);
    check("R7 pow2 hit", 1'b1, 0, 3'd2, 1'b0);
    access(2'd0, 2'd2, 64'h1008, 64'h0);
    check("R7 pow2 miss", 1'b0, 0, '0, 1'b0);
    c_cmp[0] = '1;
    access(2'd0, 2'd2, 64'h1234_5678_9ABC_DEF0, 64'h0);
    check("R7 all ones", 1'b1, 0, 3'd2, 1'b0);

    arm(0, 3'd4, 64'h0000_00FF_0000_0012, 1'b0, 3'd3, 1'b1);
    access(2'd0, 2'd3, 64'h0000_0000_ABCD_0012, 64'h0);
    check("R8 mask low hit", 1'b1, 0, 3'd3, 1'b1);
    access(2'd0, 2'd3, 64'h0000_0000_ABCD_0013, 64'h0);
    check("R8 mask low miss", 1'b0, 0, '0, 1'b0);
    c_md[0] = 3'd5;
    access(2'd0, 2'd3, 64'hAB12_3412_0000_0000, 64'h0);
    check("R8 mask high hit", 1'b1, 0, 3'd3, 1'b1);
    access(2'd0, 2'd3, 64'h0000_0012_AB12_3412, 64'h0);
    check("R8 mask high hit low ignored", 1'b1, 0, 3'd3, 1'b1);
    access(2'd0, 2'd3, 64'h0000_0000_0000_0012, 64'h0);
    check("R8 mask high miss", 1'b0, 0, '0, 1'b0);

    arm(0, 3'd6, 64'h1000, 1'b0, 3'd1, 1'b0);
    access(2'd0, 2'd3, 64'h1000, 64'h0);
    check("R9 code 6", 1'b0, 0, '0, 1'b0);
    c_md[0] = 3'd7;
    access(2'd0, 2'd3, 64'h1000, 64'h0);
    check("R9 code 7", 1'b0, 0, '0, 1'b0);

    arm(0, 3'd0, 64'h1234_5678, 1'b0, 3'd4, 1'b0);
    c_sel[0] = 1'b1;
    narrow_mode = 1'b1;
    access(2'd1, 2'd3, 64'h0, 64'hFFFF_FFFF_1234_5678);
    check("R5 data narrow", 1'b1, 0, 3'd4, 1'b0);
    narrow_mode = 1'b0;
    access(2'd1, 2'd3, 64'h1234_5678, 64'hFFFF_FFFF_1234_5678);
    check("R5 data wide", 1'b0, 0, '0, 1'b0);

    clear_cfg();
    arm(0, 3'd0, 64'h40, 1'b1, 3'd1, 1'b0);
    arm(1, 3'd0, 64'h40, 1'b0, 3'd2, 1'b1);
    access(2'd0, 2'd3, 64'h40, 64'h0);
    check("R10 chain pass", 1'b1, 1, 3'd2, 1'b1);
    c_cmp[0] = 64'h41;
    arm(2, 3'd0, 64'h40, 1'b0, 3'd6, 1'b0);
    access(2'd0, 2'd3, 64'h40, 64'h0);
    check("R10 broken chain skips end", 1'b1, 2, 3'd6, 1'b0);
    clear_cfg();
    arm(3, 3'd0, 64'h40, 1'b1, 3'd1, 1'b0);
    access(2'd0, 2'd3, 64'h40, 64'h0);
    check("R10 dangling chain", 1'b0, 0, '0, 1'b0);

    clear_cfg();
    arm(1, 3'd2, 64'h0, 1'b0, 3'd3, 1'b1);
    arm(3, 3'd0, 64'h80, 1'b0, 3'd7, 1'b0);
    access(2'd2, 2'd0, 64'h80, 64'h0);
    check("R11 lowest index", 1'b1, 1, 3'd3, 1'b1);

    for (int k = 0; k < 3000; k++) begin
      for (int i = 0; i < NT; i++) begin
        c_op[i] = 3'($urandom); c_pv[i] = 4'($urandom); c_md[i] = 3'($urandom);
        c_sel[i] = 1'($urandom); c_ch[i] = ($urandom % 4) == 0; c_tm[i] = 1'($urandom);
        c_act[i] = 3'($urandom);
        c_cmp[i] = ($urandom % 2) ? {32'($urandom), 32'($urandom)} : {32'($urandom % 256), 32'($urandom % 64)};
      end
      dbg_mode = ($urandom % 16) == 0;
      narrow_mode = ($urandom % 4) == 0;
      acc_valid = 1'b1;
      acc_op = 2'($urandom);
      cur_priv = 2'($urandom);
      acc_addr = ($urandom % 2) ? c_cmp[$urandom % NT] + 64'($urandom % 3) : {32'($urandom), 32'($urandom % 64)};
      acc_data = ($urandom % 2) ? c_cmp[$urandom % NT] : {32'($urandom % 256), 32'($urandom)};
      model(eh, ei);
      @(negedge clk);
      check("R11 random model", eh, ei, eh ? c_act[ei] : '0, eh ? c_tm[ei] : 1'b0);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule